// File: doc/BRIEF.md
# Array-Based FIFO Queue Lock

This block arbitrates one shared resource among a fixed set of requesters and hands it out in strict arrival order. Each requester signals that it wants the lock with a one-cycle acquire pulse. The block then gives that requester a private slot in a ring of availability flags. The slot comes from a pointer that is read and advanced by one in a single step, wrapping at the ring size. The requester waits until its own flag reads available, takes the lock and clears that flag. When it releases, only the flag of the next slot in the ring is set, so exactly one waiter is woken per release.

Requesters that ask in the same cycle are given slots one per cycle, lowest index first. After that, grants follow the order in which slots were handed out, and requester index plays no part. A release pulse from a requester that does not hold the lock changes nothing, and the block raises an error pulse for it.

Top module: `qlock_array_top`

## Requirements
- R1: After reset no grant and no error is raised, slot 0 is the only available slot and the pointer is 0. An acquire pulse to a free lock makes that requester's `granted` bit rise two clock edges after the edge that samples the pulse.
- R2: Each slot fetch takes the current pointer value and advances it by one, modulo NUM_REQ. After NUM_REQ fetches the pointer is back at its starting value.
- R3: When several requesters contend in the same cycle, one slot is handed out per cycle, to the lowest-indexed contender first.
- R4: Grants are given in the order in which slots were fetched, not in order of requester index.
- R5: A release by the holder drops its `granted` bit at the release edge and makes only the following slot available. A waiter on that slot is granted at the next edge, which leaves exactly one cycle with no grant.
- R6: A release pulse from a requester that is not holding the lock has no effect on grants or slots. `rel_err` is high for exactly the one cycle after the edge that samples that pulse.
- R7: At most one bit of `granted` is high at any time. The availability flags and the holders together always amount to exactly one token.
- R8: An acquire pulse from a requester that is already pending, waiting or holding is ignored and takes no extra slot.
- R9: A granted requester clears its own slot flag, so the slot can be used again after the pointer wraps. Every acquire of a free lock keeps the two-edge latency of R1 across wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_req | input | NUM_REQ | One-cycle acquire pulse per requester |
| rel_req | input | NUM_REQ | One-cycle release pulse per requester |
| granted | output | NUM_REQ | High while the requester holds the lock |
| rel_err | output | 1 | One-cycle pulse after a release by a non-holder |

## Verification
A wrong pointer or a stale slot record shows at the ports as a grant going to the wrong requester, or as a lock that is never handed on. This becomes visible at the first release after the fault, or at the first acquire once the pointer has wrapped. A flag that is set twice or lost breaks the single-token rule: either two grant bits are high together, or the ring stalls with no grant at all. The bench catches either case within one release-to-grant interval. The checks therefore walk the ring through several full wraps, vary the arrival order against the index order, and confirm the one-cycle gap after every release.

// File: rtl/qlock_pkg.sv
package qlock_pkg;

  typedef enum logic [1:0] {
    RQ_IDLE = 2'd0,
    RQ_PEND = 2'd1,
    RQ_WAIT = 2'd2,
    RQ_HOLD = 2'd3
  } rq_state_e;

  // Successor of a ring position, modulo n.
  function automatic int unsigned ring_next(input int unsigned pos, input int unsigned n);
    return (pos + 1 >= n) ? 0 : pos + 1;
  endfunction

endpackage

// File: rtl/qlock_slot_dispenser.sv
module qlock_slot_dispenser #(
  parameter int NUM_REQ = 4,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] contend,
  output logic [NUM_REQ-1:0] win,
  output logic [IDX_W-1:0]   slot_ptr
);
  import qlock_pkg::*;

  logic found;
  logic take;

  always_comb begin
    win   = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (contend[i] && !found) begin
        win[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end

  assign take = |contend;

  always_ff @(posedge clk) begin
    if (!rst_n) slot_ptr <= '0;
    else if (take) slot_ptr <= IDX_W'(ring_next(int'(slot_ptr), NUM_REQ));
  end

  // R3
  one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|contend) |-> ($countones(win) == 1));

  // R2
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(slot_ptr));

endmodule

// File: rtl/qlock_requester.sv
module qlock_requester #(
  parameter int NUM_REQ = 4,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acq,
  input  logic               rel,
  input  logic               win,
  input  logic [IDX_W-1:0]   slot_ptr,
  input  logic [NUM_REQ-1:0] flags,
  output logic               contend,
  output logic               holding,
  output logic               grant_evt,
  output logic               rel_evt,
  output logic               rel_bad,
  output logic [IDX_W-1:0]   my_slot
);
  import qlock_pkg::*;

  rq_state_e state;

  assign contend   = (state == RQ_PEND) || (state == RQ_IDLE && acq);
  assign grant_evt = (state == RQ_WAIT) && flags[my_slot];
  assign rel_evt   = (state == RQ_HOLD) && rel;
  assign rel_bad   = rel && (state != RQ_HOLD);
  assign holding   = (state == RQ_HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= RQ_IDLE;
      my_slot <= '0;
    end else begin
      unique case (state)
        RQ_IDLE: if (acq) begin
          if (win) begin
            state   <= RQ_WAIT;
            my_slot <= slot_ptr;
          end else begin
            state <= RQ_PEND;
          end
        end
        RQ_PEND: if (win) begin
          state   <= RQ_WAIT;
          my_slot <= slot_ptr;
        end
        RQ_WAIT: if (grant_evt) state <= RQ_HOLD;
        RQ_HOLD: if (rel) state <= RQ_IDLE;
        default: state <= RQ_IDLE;
      endcase
    end
  end

  // R5
  hold_until_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (holding && !rel) |=> holding);

  // R8
  slot_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RQ_WAIT) |=> $stable(my_slot));

endmodule

// File: rtl/qlock_flag_ring.sv
module qlock_flag_ring #(
  parameter int NUM_REQ = 4,
  parameter int IDX_W   = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_REQ-1:0]            grant_evt,
  input  logic [NUM_REQ-1:0]            rel_evt,
  input  logic [NUM_REQ-1:0][IDX_W-1:0] slot_of,
  output logic [NUM_REQ-1:0]            flags
);
  import qlock_pkg::*;

  logic [NUM_REQ-1:0] flags_nx;

  always_comb begin
    flags_nx = flags;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (grant_evt[i]) flags_nx[slot_of[i]] = 1'b0;
      if (rel_evt[i])   flags_nx[IDX_W'(ring_next(int'(slot_of[i]), NUM_REQ))] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= NUM_REQ'(1);
    else        flags <= flags_nx;
  end

  // R7
  single_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flags));

endmodule

// File: rtl/qlock_array_top.sv
module qlock_array_top #(
  parameter int NUM_REQ = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] acq_req,
  input  logic [NUM_REQ-1:0] rel_req,
  output logic [NUM_REQ-1:0] granted,
  output logic               rel_err
);
  localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

  logic [NUM_REQ-1:0]            contend;
  logic [NUM_REQ-1:0]            win;
  logic [NUM_REQ-1:0]            grant_evt;
  logic [NUM_REQ-1:0]            rel_evt;
  logic [NUM_REQ-1:0]            rel_bad;
  logic [NUM_REQ-1:0]            flags;
  logic [NUM_REQ-1:0][IDX_W-1:0] slot_of;
  logic [IDX_W-1:0]              slot_ptr;

  qlock_slot_dispenser #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) u_disp (
    .clk(clk), .rst_n(rst_n), .contend(contend), .win(win), .slot_ptr(slot_ptr)
  );

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
    qlock_requester #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) u_req (
      .clk(clk), .rst_n(rst_n),
      .acq(acq_req[g]), .rel(rel_req[g]), .win(win[g]),
      .slot_ptr(slot_ptr), .flags(flags),
      .contend(contend[g]), .holding(granted[g]),
      .grant_evt(grant_evt[g]), .rel_evt(rel_evt[g]), .rel_bad(rel_bad[g]),
      .my_slot(slot_of[g])
    );
  end

  qlock_flag_ring #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .grant_evt(grant_evt), .rel_evt(rel_evt),
    .slot_of(slot_of), .flags(flags)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rel_err <= 1'b0;
    else        rel_err <= |rel_bad;
  end

  // R7
  mutex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(granted));

  // R7
  one_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(flags) + $countones(granted)) == 1);

  // R6
  bad_rel_no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|rel_bad) && !(|rel_evt)) |=> (granted & ~$past(granted)) == (granted ^ $past(granted)));

endmodule

// File: tb/qlock_array_top_tb.sv
module qlock_array_top_tb;
  localparam int P = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [P-1:0] acq_req;
  logic [P-1:0] rel_req;
  logic [P-1:0] granted;
  logic         rel_err;

  int n_checks = 0;
  int n_errors = 0;
  int mutex_viol = 0;

  always #10 clk = ~clk;

  qlock_array_top #(.NUM_REQ(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .acq_req(acq_req), .rel_req(rel_req),
    .granted(granted), .rel_err(rel_err)
  );

  always @(negedge clk) if (rst_n && $countones(granted) > 1) mutex_viol++;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_grant(input string req, input logic [P-1:0] exp);
    check(granted == exp, req, int'(granted), int'(exp));
  endtask

  task automatic pulse_acq(input logic [P-1:0] v);
    acq_req = v; tick(); acq_req = '0;
  endtask

  // Release by the holder: one empty cycle, then the next holder (R5).
  task automatic release_then(input int who, input logic [P-1:0] next_exp);
    rel_req = '0; rel_req[who] = 1'b1; tick(); rel_req = '0;
    chk_grant("R5 gap", '0);
    tick();
    chk_grant("R4/R5 next holder", next_exp);
  endtask

  task automatic t_reset();
    chk_grant("R1 reset grant", '0);
    check(rel_err == 1'b0, "R1 reset err", int'(rel_err), 0);
  endtask

  task automatic t_single();
    pulse_acq(4'b0001);
    chk_grant("R1 latency early", '0);
    tick();
    chk_grant("R1 latency", 4'b0001);
    release_then(0, '0);
  endtask

  // ptr=1, flag1 set: all contend together, slots 1,2,3,0 to 0,1,2,3.
  task automatic t_all_same_cycle();
    pulse_acq(4'b1111);
    chk_grant("R3 first slot", '0);
    tick();
    chk_grant("R3 lowest first", 4'b0001);
    release_then(0, 4'b0010);
    release_then(1, 4'b0100);
    release_then(2, 4'b1000);
    release_then(3, '0);
  endtask

  // ptr=1 again (R2 wrap), flag1 set: arrivals 3,1,0 get slots 1,2,3.
  task automatic t_arrival_order();
    acq_req = 4'b1000; tick();
    acq_req = 4'b0010; tick();
    acq_req = 4'b0001; tick();
    acq_req = '0;
    chk_grant("R2 wrap / R4 first arrival", 4'b1000);
    release_then(3, 4'b0010);
    // R8: duplicate acquires from holder 1 and waiter 0
    pulse_acq(4'b0011);
    chk_grant("R8 holder kept", 4'b0010);
    release_then(1, 4'b0001);
    release_then(0, '0);
    repeat (3) tick();
    chk_grant("R8 no extra slot", '0);
  endtask

  // ptr=0, flag0 set.
  task automatic t_bad_release();
    rel_req = 4'b0100; tick(); rel_req = '0;
    check(rel_err == 1'b1, "R6 err pulse", int'(rel_err), 1);
    chk_grant("R6 no grant", '0);
    tick();
    check(rel_err == 1'b0, "R6 err one cycle", int'(rel_err), 0);
    pulse_acq(4'b0100); tick();
    chk_grant("R6 ring intact", 4'b0100);
    rel_req = 4'b0001; tick(); rel_req = '0;
    check(rel_err == 1'b1, "R6 err while held", int'(rel_err), 1);
    chk_grant("R6 holder kept", 4'b0100);
    release_then(2, '0);
  endtask

  task automatic t_wrap_latency();
    for (int k = 0; k < 2 * P + 1; k++) begin
      logic [P-1:0] v;
      v = '0; v[k % P] = 1'b1;
      pulse_acq(v);
      tick();
      chk_grant("R9 latency after wrap", v);
      release_then(k % P, '0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; acq_req = '0; rel_req = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_all_same_cycle();
    t_arrival_order();
    t_bad_release();
    t_wrap_latency();
    check(mutex_viol == 0, "R7 mutual exclusion", mutex_viol, 0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule